// File: doc/BRIEF.md
# Serial Configuration Loader for Chained Multi-Queue Buffers

This block holds the configuration image for a chain of multi-queue buffer devices and shifts that image out, one bit per clock. The image consists of 18-bit register words: one global word, then four words for each configured queue. A single end-of-configuration bit follows the last word. Each bit goes out on a serial data pin while an active-low serial enable is low. When the devices are chained, each device passes its serial data and enable on to the next one. The whole chain is configured only when the enable output of the tail device goes low. The loader waits for that event before it reports completion.

A start pulse launches one configuration pass. While the pass runs, the busy output stays high. The pass ends in one of two ways. If the tail enable comes back, done goes high and stays high until the next start. If the tail enable stays high longer than a programmable number of cycles, an error flag is raised. The outgoing serial stream works as a valid-only stream. The low enable marks each valid bit, and the receiving chain has no way to stall it, so there is no back-pressure. The load cycle before each word is the only gap in the stream.

Top module: `sercfg_loader`

## Requirements
- R1: After reset, sen_n_o is 1 and sdo_o, busy_o, done_o and err_o are 0.
- R2: The image has 1+4·QUEUES words. Word k equals (k·IMG_MUL + IMG_ADD) mod 2^18, with defaults IMG_MUL = 0x01E37 and IMG_ADD = 0x2A5C3. Each word is sent most significant bit first, one bit per clock, and sdo_o is valid in every cycle where sen_n_o is 0.
- R3: One pass presents exactly 18 + 72·QUEUES + 1 bits with sen_n_o low. The final bit is the end marker and has the value 1.
- R4: Before each word and before the end marker, sen_n_o is high for exactly one load cycle. A pass therefore contains 2+4·QUEUES such cycles.
- R5: busy_o rises in the cycle after start_i is sampled in the idle or done state. It stays high until the pass ends in done or in error.
- R6: After the last bit, the loader waits for chain_sen_n_i to be low. When it samples that low value, done_o goes high and busy_o goes low. done_o holds until the next start.
- R7: The wait has a window of timeout_i+1 sampled cycles. If chain_sen_n_i is high in all of them, err_o goes high, busy_o goes low and done_o stays 0. If the tail enable arrives in the last cycle of the window, the tail enable wins.
- R8: A low chain_sen_n_i while bits are still being shifted is ignored. The full stream is sent, and done_o rises only after the end marker.
- R9: A start_i pulse while busy_o is high is ignored. The stream neither restarts nor changes.
- R10: A new start clears err_o and done_o.
- R11: After an error, a later low chain_sen_n_i does not set done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start one configuration pass |
| timeout_i | input | TMO_W | Wait window length minus one, in cycles |
| chain_sen_n_i | input | 1 | Active-low enable returned from the tail of the chain |
| sdo_o | output | 1 | Serial configuration data |
| sen_n_o | output | 1 | Active-low serial enable, low for each valid bit |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | Chain reported configuration complete |
| err_o | output | 1 | Tail enable did not return within the window |

## Verification
The tail-enable detector and the timeout detector can both act on the same cycle: the last cycle of the wait window. The bench sweeps the arrival of the tail enable over every cycle offset from the first wait cycle up to two cycles past the window, for several window lengths, including a window of a single cycle. For each offset, the expected outcome follows from comparing the offset with timeout_i. An offset equal to timeout_i must give done with no error, and one larger must give error with no done.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int WORD_W     = 18;
  localparam int REGS_PER_Q = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_WAIT,
    ST_DONE
  } ld_state_t;
endpackage

// File: rtl/cfgld_image.sv
module cfgld_image #(
  parameter int QUEUES  = 2,
  parameter int WORD_W  = 18,
  parameter int IMG_MUL = 32'h01E37,
  parameter int IMG_ADD = 32'h2A5C3,
  localparam int NWORDS = 1 + 4 * QUEUES,
  localparam int IDX_W  = $clog2(NWORDS + 1),
  localparam int LEN_W  = $clog2(WORD_W + 1)
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] word_o,
  output logic [LEN_W-1:0]  len_o
);
  logic [31:0] prod;

  always_comb begin
    prod = 32'(idx_i) * 32'(IMG_MUL) + 32'(IMG_ADD);
    if (32'(idx_i) == 32'(NWORDS)) begin
      // end-of-configuration marker: a single 1 bit in the top position
      word_o = {1'b1, {(WORD_W-1){1'b0}}};
      len_o  = LEN_W'(1);
    end else begin
      word_o = prod[WORD_W-1:0];
      len_o  = LEN_W'(WORD_W);
    end
  end
endmodule

// File: rtl/cfgld_serializer.sv
module cfgld_serializer #(
  parameter int WORD_W = 18,
  localparam int LEN_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              bit_o,
  output logic              last_o
);
  logic [WORD_W-1:0] sreg_q;
  logic [LEN_W-1:0]  rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      sreg_q <= word_i;
      rem_q  <= len_i;
    end else if (shift_i && rem_q != '0) begin
      sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
      rem_q  <= rem_q - LEN_W'(1);
    end
  end

  assign bit_o  = sreg_q[WORD_W-1];
  assign last_o = (rem_q == LEN_W'(1));

  // R4: a new word is only loaded once the previous one has drained
  a_r4_load_drained: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> rem_q == '0);

  // R2: most significant bit first, one position per shift
  a_r2_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i && rem_q > LEN_W'(1)) |=> bit_o == $past(sreg_q[WORD_W-2]));
endmodule

// File: rtl/cfgld_chain_watch.sv
module cfgld_chain_watch #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             chain_n_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             seen_o,
  output logic             expire_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!active_i)         cnt_q <= '0;
    else if (cnt_q != limit_i)  cnt_q <= cnt_q + TMO_W'(1);
  end

  // tail enable has priority over the window end in the same cycle
  assign seen_o   = active_i && !chain_n_i;
  assign expire_o = active_i && chain_n_i && (cnt_q == limit_i);

  // R7: expiry in a later cycle needs the window to have been running
  a_r7_expire_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && limit_i != '0) |-> $past(active_i));
endmodule

// File: rtl/sercfg_loader.sv
module sercfg_loader
  import cfgld_pkg::*;
#(
  parameter int QUEUES  = 2,
  parameter int TMO_W   = 8,
  parameter int IMG_MUL = 32'h01E37,
  parameter int IMG_ADD = 32'h2A5C3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic             chain_sen_n_i,
  output logic             sdo_o,
  output logic             sen_n_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int NWORDS = 1 + REGS_PER_Q * QUEUES;
  localparam int IDX_W  = $clog2(NWORDS + 1);
  localparam int LEN_W  = $clog2(WORD_W + 1);

  ld_state_t         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              err_q;
  logic [WORD_W-1:0] img_word;
  logic [LEN_W-1:0]  img_len;
  logic              ser_bit, ser_last;
  logic              ch_seen, ch_expire;
  logic              idle_like;
  logic              at_marker;

  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign at_marker = (32'(idx_q) == 32'(NWORDS));

  cfgld_image #(
    .QUEUES (QUEUES),
    .WORD_W (WORD_W),
    .IMG_MUL(IMG_MUL),
    .IMG_ADD(IMG_ADD)
  ) u_image (
    .idx_i (idx_q),
    .word_o(img_word),
    .len_o (img_len)
  );

  cfgld_serializer #(
    .WORD_W(WORD_W)
  ) u_ser (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (state_q == ST_LOAD),
    .shift_i(state_q == ST_SHIFT),
    .word_i (img_word),
    .len_i  (img_len),
    .bit_o  (ser_bit),
    .last_o (ser_last)
  );

  cfgld_chain_watch #(
    .TMO_W(TMO_W)
  ) u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (state_q == ST_WAIT),
    .chain_n_i(chain_sen_n_i),
    .limit_i  (timeout_i),
    .seen_o   (ch_seen),
    .expire_o (ch_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            state_q <= ST_LOAD;
            idx_q   <= '0;
            err_q   <= 1'b0;
          end
        end
        ST_LOAD: state_q <= ST_SHIFT;
        ST_SHIFT: begin
          if (ser_last) begin
            if (at_marker) begin
              state_q <= ST_WAIT;
            end else begin
              idx_q   <= idx_q + IDX_W'(1);
              state_q <= ST_LOAD;
            end
          end
        end
        ST_WAIT: begin
          if (ch_seen) begin
            state_q <= ST_DONE;
          end else if (ch_expire) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sen_n_o = (state_q != ST_SHIFT);
  assign sdo_o   = (state_q == ST_SHIFT) ? ser_bit : 1'b0;
  assign busy_o  = !idle_like;
  assign done_o  = (state_q == ST_DONE);
  assign err_o   = err_q;

  // R6: done only follows a sampled low tail enable
  a_r6_done_needs_chain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(!chain_sen_n_i));

  // R7: error only rises out of the wait with the tail enable still high
  a_r7_err_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> ($past(state_q == ST_WAIT) && $past(chain_sen_n_i)));

  // R9: a start pulse mid-word leaves the shift running
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT && start_i && !ser_last) |=> state_q == ST_SHIFT);

  // R3: the end marker bit is a 1
  a_r3_marker_one: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT && at_marker) |-> sdo_o);

  // R5: busy and done never overlap
  a_r5_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
endmodule

// File: tb/sercfg_loader_tb.sv
module sercfg_loader_tb;
  localparam int QUEUES = 2;
  localparam int TMO_W  = 8;
  localparam int NWORDS = 1 + 4 * QUEUES;
  localparam int TOTAL  = 18 + 72 * QUEUES + 1;
  localparam int MUL    = 32'h01E37;
  localparam int ADD    = 32'h2A5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [TMO_W-1:0] timeout_i = '0;
  logic chain_sen_n_i = 1'b1;
  logic sdo_o, sen_n_o, busy_o, done_o, err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sercfg_loader #(.QUEUES(QUEUES), .TMO_W(TMO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .timeout_i(timeout_i),
    .chain_sen_n_i(chain_sen_n_i), .sdo_o(sdo_o), .sen_n_o(sen_n_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_bit(input int n);
    int k, b;
    logic [31:0] w;
    if (n == TOTAL - 1) return 1'b1;
    k = n / 18;
    b = 17 - (n % 18);
    w = 32'(k) * 32'(MUL) + 32'(ADD);
    return w[b];
  endfunction

  // one pass; tail enable lowered d cycles into the wait (or early)
  task automatic run_pass(input int t, input int d, input bit early, input bit poke);
    int nb = 0, gaps = 0, bad = 0, early_done = 0, guard = 0;
    timeout_i = TMO_W'(t);
    chain_sen_n_i = early ? 1'b0 : 1'b1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(err_o == 1'b0 && done_o == 1'b0, "R10 flags cleared", {err_o, done_o}, 0);
    chk(busy_o == 1'b1, "R5 busy after start", busy_o, 1);
    forever begin
      guard++;
      if (done_o) early_done++;
      if (!busy_o) bad++;
      if (!sen_n_o) begin
        if (sdo_o != exp_bit(nb)) bad++;
        nb++;
      end else gaps++;
      if (nb == TOTAL || guard > 4 * TOTAL) break;
      start_i = (poke && nb == 40) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(bad == 0, "R2 bit stream", bad, 0);
    chk(nb == TOTAL, "R3 bit count", nb, TOTAL);
    chk(gaps == NWORDS + 1, "R4 load gaps", gaps, NWORDS + 1);
    if (early) chk(early_done == 0, "R8 early chain ignored", early_done, 0);
    if (poke) chk(bad == 0 && nb == TOTAL, "R9 start while busy", nb, TOTAL);
    if (early) begin
      repeat (3) @(negedge clk);
      chk(done_o == 1'b1 && err_o == 1'b0, "R8 done after marker", done_o, 1);
    end else begin
      repeat (1 + d) @(negedge clk);
      chain_sen_n_i = 1'b0;
      repeat (3) @(negedge clk);
      if (d <= t) begin
        chk(done_o == 1'b1, "R6 done", done_o, 1);
        chk(err_o == 1'b0, "R7 no error in window", err_o, 0);
      end else begin
        chk(err_o == 1'b1, "R7 timeout error", err_o, 1);
        chk(done_o == 1'b0, "R11 late chain ignored", done_o, 0);
      end
      chk(busy_o == 1'b0, "R5 busy cleared", busy_o, 0);
    end
    chain_sen_n_i = 1'b1;
    repeat (2) @(negedge clk);
    if (d <= t || early) chk(done_o == 1'b1, "R6 done holds", done_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sen_n_o == 1'b1 && sdo_o == 1'b0, "R1 serial idle", {sen_n_o, sdo_o}, 2);
    chk(busy_o == 0 && done_o == 0 && err_o == 0, "R1 status", {busy_o, done_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sen_n_o == 1'b1 && busy_o == 1'b0, "R1 after release", {sen_n_o, busy_o}, 2);
    foreach (tl[i]) begin end
    for (int ti = 0; ti < 3; ti++) begin
      int t = (ti == 0) ? 0 : (ti == 1) ? 1 : 3;
      for (int d = 0; d <= t + 2; d++) run_pass(t, d, 1'b0, 1'b0);
    end
    run_pass(2, 0, 1'b1, 1'b0);
    run_pass(4, 1, 1'b0, 1'b1);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  int tl[1];

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule